// File: doc/BRIEF.md
# Parallel Byte-Aligned Run Detector

The detector watches a stream of wide data words and reports, every time a word is accepted, at which byte boundaries of the preceding word a run of nine equal bits begins. The run may consist of ones or of zeros. Bit 0 is the earliest bit in stream order. Flag k describes a run that starts at bit 8k and ends at bit 8k+8.

The run that starts at the last boundary needs one bit from the next word. For this reason, the block keeps each accepted word and evaluates it only when its successor arrives. The held word forms the low 64 bits of a 65-bit view, and bit 0 of the newly accepted word becomes bit 64 of that view. Each boundary is tested in parallel: the nine-bit window is compared with a copy of itself shifted by one bit. Each flag is therefore one level of pairwise XNOR gates followed by a short AND tree, so its depth does not depend on the data.

The flags are registered and come with a valid strobe. The flags lag the input by one accepted word. Idle cycles between words do not break the pairing of a word with its successor.

Top module: `byte_run_detector`

## Requirements
- R1: Flag k (bit k of `run_flags`) is 1 exactly when bits 8k through 8k+8 of the 65-bit view are all equal. The low 64 bits of the view are the previously accepted word, and bit 64 is bit 0 of the word just accepted.
- R2: A run of nine ones and a run of nine zeros are both reported.
- R3: When only eight bits starting at a boundary are equal and the ninth differs, no flag is reported for that boundary.
- R4: When a word is accepted while an earlier word is held, `run_valid` is 1 in the following cycle, and `run_flags` then describes the earlier word.
- R5: In any cycle that follows a clock edge at which no word pair completed, `run_valid` is 0 and `run_flags` is all zeros.
- R6: Idle cycles (`word_valid` low) leave the held word unchanged. The next accepted word, however many cycles later it arrives, supplies bit 64 for it.
- R7: A synchronous reset (`rst` high at a clock edge) clears the held word's validity, `run_valid` and `run_flags`. The first word accepted after reset produces no output.
- R8: A run at boundary 7 that continues into bit 0 of the following word is flagged, and is not flagged when that bit differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Qualifies `word_in` for this cycle |
| word_in | input | 64 | Data word, bit 0 earliest |
| run_valid | output | 1 | `run_flags` holds results for one word |
| run_flags | output | 8 | One flag per byte boundary of the evaluated word |

## Verification
The bench builds the block with its defaults: 64-bit words split at 8-bit boundaries. With these values there are eight windows, including the one at boundary 7, whose last bit comes from the next word, so cross-word runs can be produced with ordinary stimulus. Byte-sized fields also make it easy to write words of solid bytes, eight-bit runs that end one bit short, and random words built from mixed solid and noisy bytes that hit many flag combinations. Idle gaps and a reset in the middle of the stream exercise the word pairing.

// File: rtl/brd_pkg.sv
package brd_pkg;

    // Default geometry of the detector.
    localparam int BRD_DATA_W = 64;
    localparam int BRD_SEG_W  = 8;

    // Number of byte boundaries examined per word.
    function automatic int brd_seg_count(input int data_w, input int seg_w);
        return data_w / seg_w;
    endfunction

endpackage

// File: rtl/run_window_cmp.sv
// One window test: all bits equal when every adjacent pair matches.
module run_window_cmp #(
    parameter int WIN_W = 9
) (
    input  logic [WIN_W-1:0] win,
    output logic             hit
);
    logic [WIN_W-2:0] pair_eq;

    always_comb begin
        pair_eq = win[WIN_W-1:1] ~^ win[WIN_W-2:0];
        hit     = &pair_eq;
    end
endmodule

// File: rtl/run_flag_array.sv
// Parallel set of window tests, one per segment boundary.
module run_flag_array #(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8,
    localparam int NSEG  = DATA_W / SEG_W
) (
    input  logic [DATA_W:0]   view,
    output logic [NSEG-1:0]   hit
);
    for (genvar k = 0; k < NSEG; k++) begin : g_win
        run_window_cmp #(
            .WIN_W(SEG_W + 1)
        ) u_cmp (
            .win(view[k*SEG_W +: SEG_W+1]),
            .hit(hit[k])
        );
    end
endmodule

// File: rtl/byte_run_detector.sv
module byte_run_detector
    import brd_pkg::*;
#(
    parameter int DATA_W = BRD_DATA_W,
    parameter int SEG_W  = BRD_SEG_W,
    localparam int NSEG  = brd_seg_count(DATA_W, SEG_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_in,
    output logic              run_valid,
    output logic [NSEG-1:0]   run_flags
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              hold_vld;
        logic [NSEG-1:0]   flags;
        logic              out_vld;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W:0]  view;
    logic [NSEG-1:0]  hit;

    // Wire-only view: held word plus the first bit of its successor.
    assign view = {word_in[0], st_q.hold};

    run_flag_array #(
        .DATA_W(DATA_W),
        .SEG_W (SEG_W)
    ) u_flags (
        .view(view),
        .hit (hit)
    );

    always_comb begin
        st_d = st_q;
        st_d.out_vld = word_valid && st_q.hold_vld;
        st_d.flags   = (word_valid && st_q.hold_vld) ? hit : '0;
        if (word_valid) begin
            st_d.hold     = word_in;
            st_d.hold_vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_valid = st_q.out_vld;
    assign run_flags = st_q.flags;

    // Names seen by the bound checker.
    logic              hold_vld_q;
    logic [DATA_W-1:0] hold_q;
    assign hold_vld_q = st_q.hold_vld;
    assign hold_q     = st_q.hold;
endmodule

// File: rtl/byte_run_detector_chk.sv
module byte_run_detector_chk #(
    parameter int DATA_W = 64,
    parameter int NSEG   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              word_valid,
    input logic              run_valid,
    input logic [NSEG-1:0]   run_flags,
    input logic              hold_vld_q,
    input logic [DATA_W-1:0] hold_q
);
    // R4: an output word only follows an accepted input word
    a_r4_valid_follows_input: assert property (@(posedge clk) disable iff (rst)
        run_valid |-> $past(word_valid));

    // R5: no flags outside valid results
    a_r5_idle_flags_clear: assert property (@(posedge clk) disable iff (rst)
        !run_valid |-> (run_flags == '0));

    // R7: without a held word the next cycle carries no result
    a_r7_first_word_silent: assert property (@(posedge clk) disable iff (rst)
        !hold_vld_q |=> !run_valid);

    // R6: idle cycles keep the held word
    a_r6_hold_persists: assert property (@(posedge clk) disable iff (rst)
        (hold_vld_q && !word_valid) |=> (hold_vld_q && $stable(hold_q)));
endmodule

bind byte_run_detector byte_run_detector_chk #(
    .DATA_W(DATA_W),
    .NSEG  (NSEG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .word_valid(word_valid),
    .run_valid (run_valid),
    .run_flags (run_flags),
    .hold_vld_q(hold_vld_q),
    .hold_q    (hold_q)
);

// File: tb/byte_run_detector_test.sv
module byte_run_detector_test;
    localparam int DW = 64;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          word_valid = 1'b0;
    logic [DW-1:0] word_in = '0;
    logic          run_valid;
    logic [NS-1:0] run_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [NS-1:0] flags;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] prev_word;
    bit            prev_vld = 0;

    always #2 clk = ~clk;   // 250 MHz

    byte_run_detector uut (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
        .run_valid(run_valid), .run_flags(run_flags)
    );

    function automatic logic [NS-1:0] ref_flags(input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW:0]   v;
        logic [NS-1:0] f;
        v = {b[0], a};
        for (int k = 0; k < NS; k++) begin
            f[k] = 1'b1;
            for (int j = 1; j <= 8; j++)
                if (v[8*k+j] != v[8*k]) f[k] = 1'b0;
        end
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    // Driver: present one word, push the expected result of the pair.
    task automatic send(input logic [DW-1:0] w, input string tag);
        if (prev_vld) sb.push_back('{ref_flags(prev_word, w), tag});
        prev_word = w;
        prev_vld  = 1;
        @(posedge clk); #1;
        word_valid = 1'b1;
        word_in    = w;
        @(posedge clk); #1;
        word_valid = 1'b0;
        word_in    = $urandom() % 2 == 0 ? '0 : '1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && !done) begin
                if (run_valid) begin
                    if (sb.size() == 0) begin
                        check(0, "R7", "unexpected run_valid", "no result");
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(run_flags == e.flags, e.tag,
                              $sformatf("%b", run_flags), $sformatf("%b", e.flags));
                    end
                end else begin
                    check(run_flags == '0, "R5", $sformatf("%b", run_flags), "00000000");
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(!run_valid && run_flags == '0, "R7", $sformatf("%b/%b", run_valid, run_flags), "0/0");

        // R7: first word silent (monitor fails on stray run_valid)
        send('1, "R7");
        // R2 ones everywhere, then zeros everywhere: bit64 of the ones word is 0 -> flag7 off
        send('1, "R2");
        send('0, "R2 R8");
        send('0, "R2");
        // alternating bits: no run
        send({16{4'h5}}, "R1");
        send({16{4'h5}}, "R1");
        // R3: byte 0 ones, bit 8 zero -> eight ones only
        send({{7{8'hAA}}, 8'hFF}, "R3");
        // R3 zeros variant: byte 3 zeros then bit 32 one
        send({{4{8'h55}}, 8'h00, {3{8'hAA}}}, "R3");
        send({{4{8'h55}}, 8'h01, 8'hFF, 8'h00, 8'h00}, "R1");
        // R8: top byte ones, next bit0 one -> flag7; then bit0 zero -> no flag7
        send({8'hFF, {7{8'h5A}}}, "R8");
        send({8'hFF, {7{8'h5B}}}, "R8");
        send({8'h00, {7{8'h5A}}}, "R8");
        send({{7{8'h5A}}, 8'h00}, "R8");
        // R6: idle gaps keep pairing
        send({8'hFF, {7{8'h33}}}, "R6");
        idle(5);
        send({{7{8'h33}}, 8'h01}, "R6");
        idle(3);
        send('1, "R6");
        // R7: mid-stream reset discards held word
        @(posedge clk); #1;
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        prev_vld = 0;
        sb.delete();
        @(negedge clk);
        check(!run_valid && run_flags == '0, "R7", $sformatf("%b/%b", run_valid, run_flags), "0/0");
        send('1, "R7");
        send('1, "R4");
        // R4 random with solid bytes mixed in
        for (int i = 0; i < 300; i++) begin
            logic [DW-1:0] w;
            w = {$urandom(), $urandom()};
            for (int b = 0; b < NS; b++) begin
                case ($urandom() % 4)
                    0: w[8*b +: 8] = 8'hFF;
                    1: w[8*b +: 8] = 8'h00;
                    default: ;
                endcase
            end
            send(w, "R4 R1");
            if ($urandom() % 5 == 0) idle($urandom() % 3);
        end
        idle(4);
        check(sb.size() == 0, "R4", $sformatf("%0d pending", sb.size()), "0 pending");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule